// File: doc/BRIEF.md
# Configurable Logic Cell Array

The block is a row of identical configurable logic cells, each one a single stage of a programmable logic block. A cell receives a sum-of-products term and a pad input of its own, plus a product-term clock and a product-term clock enable of its own. All cells share a set of global clocks, one global clock enable and one global reset. A static configuration word per cell sets how the sum is shaped and where it is stored.

Every cell drives two outputs at the same time. The combinational output carries the sum, passed through true or inverted. The stored output holds either that result or the pad input. The storage element is either an edge-triggered flip-flop or a latch that is transparent while its clock is high. Updates are qualified by a clock enable, so the clock itself is never gated. The reset clears the stored value asynchronously, and each cell sets which level of the reset is active.

The cells share nothing except the global inputs. Each one can therefore run an unrelated function, with its registered output separate from its combinational one.

Top module: `mc_block`

## Requirements
- R1: `comb_o[i]` equals `sop_i[i]` XOR the cell's invert bit (config bit 0) at all times, whatever the storage settings are.
- R2: The data stored by a cell is `pad_i[i]` when its source bit (config bit 1) is 1, and the R1 result when that bit is 0.
- R3: When the storage-mode bit (config bit 2) is 0, `reg_o[i]` changes only on a rising edge of the selected clock, and only to the data present at that edge.
- R4: When the storage-mode bit is 1, `reg_o[i]` follows the data while the selected clock is high and the enable is active. It holds its value while the clock is low.
- R5: The clock-select field (config bits 5:3) picks the clock. Values 0 to 3 pick `gclk_i[value]`, value 4 picks `ptclk_i[i]`, and values 5 to 7 pick `gclk_i[0]`.
- R6: With the enable-use bit (config bit 6) at 0, the cell is always enabled. With it at 1, the enable is `gce_i` when the enable-source bit (config bit 7) is 0 and `ptce_i[i]` when it is 1. While the enable is low, `reg_o[i]` does not change in either storage mode.
- R7: The reset is active when `grst_i` equals the reset-level bit (config bit 8). While it is active, `reg_o[i]` is 0 at once, overriding both the enable and latch transparency.
- R8: Cell i is configured only by `cfg_i[i*9 +: 9]`, so cells with different configurations run side by side under the same global inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gclk_i | input | 4 | Global clocks |
| grst_i | input | 1 | Global reset; the active level is set per cell |
| gce_i | input | 1 | Global clock enable |
| sop_i | input | NUM_CELLS | Sum-of-products term per cell |
| pad_i | input | NUM_CELLS | Direct pad input per cell |
| ptclk_i | input | NUM_CELLS | Product-term clock per cell |
| ptce_i | input | NUM_CELLS | Product-term clock enable per cell |
| cfg_i | input | NUM_CELLS*9 | Static configuration, 9 bits per cell |
| comb_o | output | NUM_CELLS | Combinational output per cell |
| reg_o | output | NUM_CELLS | Stored output per cell |

## Verification
The cell has no pipeline, so every result is due in the same time step as the stimulus that causes it. The combinational output and the reset respond at once. A flip-flop responds at the rising edge of its selected clock. A latch responds whenever its clock is high and a data or enable input changes. The bench changes one class of input at a time: data and enables with the clocks steady, or clocks with the data steady. It compares both outputs 1 ns after each change, against a reference model that has seen exactly the same ordered sequence of changes. The embedded checks sample on the edges of global clock 0 and of the product-term clocks. The edge checks compare the stored output at the next edge with data sampled at the previous edge.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned NUM_GCLK = 4;
  localparam int unsigned CSEL_W   = $clog2(NUM_GCLK + 1);

  // bit 0 is inv; the bench and the brief rely on this layout
  typedef struct packed {
    logic              rst_hi;
    logic              ce_pt;
    logic              ce_use;
    logic [CSEL_W-1:0] clk_sel;
    logic              latch;
    logic              pad_src;
    logic              inv;
  } cell_cfg_t;

  localparam int unsigned CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/mc_clk_mux.sv
module mc_clk_mux
  import mc_pkg::*;
(
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                ptclk_i,
  input  logic [CSEL_W-1:0]   sel_i,
  input  logic                gce_i,
  input  logic                ptce_i,
  input  logic                ce_use_i,
  input  logic                ce_pt_i,
  output logic                clk_o,
  output logic                en_o
);
  // select is static, so the mux never switches under a running clock
  always_comb begin
    clk_o = gclk_i[0];
    for (int k = 0; k < int'(NUM_GCLK); k++) begin
      if (sel_i == CSEL_W'(k)) clk_o = gclk_i[k];
    end
    if (sel_i == CSEL_W'(NUM_GCLK)) clk_o = ptclk_i;
  end

  assign en_o = !ce_use_i || (ce_pt_i ? ptce_i : gce_i);
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic d_i,
  input  logic latch_i,
  output logic q_o
);
  logic q_ff;
  logic q_lat;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)     q_ff <= 1'b0;
    else if (en_i) q_ff <= d_i;
  end

  always_latch begin
    if (rst_i)              q_lat <= 1'b0;
    else if (clk_i && en_i) q_lat <= d_i;
  end

  assign q_o = latch_i ? q_lat : q_ff;
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
(
  input  cell_cfg_t           cfg_i,
  input  logic                sop_i,
  input  logic                pad_i,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                ptclk_i,
  input  logic                gce_i,
  input  logic                ptce_i,
  input  logic                grst_i,
  output logic                comb_o,
  output logic                reg_o
);
  logic xor_q;
  logic d;
  logic rst;
  logic clk;
  logic en;

  assign xor_q  = sop_i ^ cfg_i.inv;
  assign comb_o = xor_q;
  assign d      = cfg_i.pad_src ? pad_i : xor_q;
  assign rst    = cfg_i.rst_hi ? grst_i : !grst_i;

  mc_clk_mux i_clk_mux (
    .gclk_i   (gclk_i),
    .ptclk_i  (ptclk_i),
    .sel_i    (cfg_i.clk_sel),
    .gce_i    (gce_i),
    .ptce_i   (ptce_i),
    .ce_use_i (cfg_i.ce_use),
    .ce_pt_i  (cfg_i.ce_pt),
    .clk_o    (clk),
    .en_o     (en)
  );

  mc_store i_store (
    .clk_i   (clk),
    .rst_i   (rst),
    .en_i    (en),
    .d_i     (d),
    .latch_i (cfg_i.latch),
    .q_o     (reg_o)
  );
endmodule

// File: rtl/mc_block.sv
module mc_block
  import mc_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 32
) (
  input  logic [NUM_GCLK-1:0]        gclk_i,
  input  logic                       grst_i,
  input  logic                       gce_i,
  input  logic [NUM_CELLS-1:0]       sop_i,
  input  logic [NUM_CELLS-1:0]       pad_i,
  input  logic [NUM_CELLS-1:0]       ptclk_i,
  input  logic [NUM_CELLS-1:0]       ptce_i,
  input  logic [NUM_CELLS*CFG_W-1:0] cfg_i,
  output logic [NUM_CELLS-1:0]       comb_o,
  output logic [NUM_CELLS-1:0]       reg_o
);
  for (genvar i = 0; i < int'(NUM_CELLS); i++) begin : g_cell
    mc_cell i_cell (
      .cfg_i   (cell_cfg_t'(cfg_i[i*CFG_W +: CFG_W])),
      .sop_i   (sop_i[i]),
      .pad_i   (pad_i[i]),
      .gclk_i  (gclk_i),
      .ptclk_i (ptclk_i[i]),
      .gce_i   (gce_i),
      .ptce_i  (ptce_i[i]),
      .grst_i  (grst_i),
      .comb_o  (comb_o[i]),
      .reg_o   (reg_o[i])
    );
  end
endmodule

// File: rtl/mc_block_chk.sv
module mc_block_chk
  import mc_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 32
) (
  input logic [NUM_GCLK-1:0]        gclk_i,
  input logic                       grst_i,
  input logic                       gce_i,
  input logic [NUM_CELLS-1:0]       sop_i,
  input logic [NUM_CELLS-1:0]       pad_i,
  input logic [NUM_CELLS-1:0]       ptclk_i,
  input logic [NUM_CELLS-1:0]       ptce_i,
  input logic [NUM_CELLS*CFG_W-1:0] cfg_i,
  input logic [NUM_CELLS-1:0]       comb_o,
  input logic [NUM_CELLS-1:0]       reg_o
);
  for (genvar i = 0; i < int'(NUM_CELLS); i++) begin : g_chk
    logic [CFG_W-1:0] cs;
    cell_cfg_t        c;
    logic             rst;
    logic             en;
    logic             d;
    logic             on_g0;

    assign cs    = cfg_i[i*CFG_W +: CFG_W];
    assign c     = cell_cfg_t'(cs);
    assign rst   = c.rst_hi ? grst_i : !grst_i;
    assign en    = !c.ce_use || (c.ce_pt ? ptce_i[i] : gce_i);
    assign d     = c.pad_src ? pad_i[i] : (sop_i[i] ^ c.inv);
    assign on_g0 = (c.clk_sel == '0) || (c.clk_sel > CSEL_W'(NUM_GCLK));

    assert_comb_xor_R1: assert property (@(posedge gclk_i[0]) disable iff (rst)
      comb_o[i] == (sop_i[i] ^ c.inv));

    // R2 R3: flop captures selected data at the edge; a config change in between voids the check
    assert_edge_capture_R3: assert property (@(posedge gclk_i[0]) disable iff (rst)
      (on_g0 && !c.latch && en) |=> (!$stable(cs) || reg_o[i] == $past(d)));

    assert_ptclk_capture_R5: assert property (@(posedge ptclk_i[i]) disable iff (rst)
      (c.clk_sel == CSEL_W'(NUM_GCLK) && !c.latch && en) |=>
      (!$stable(cs) || reg_o[i] == $past(d)));

    assert_enable_hold_R6: assert property (@(posedge gclk_i[0]) disable iff (rst)
      (on_g0 && !c.latch && !en) |=> (!$stable(cs) || reg_o[i] == $past(reg_o[i])));

    always @(negedge gclk_i[0]) begin
      if (!rst && on_g0 && c.latch && en) begin
        assert_latch_follow_R4: assert (reg_o[i] == d);
      end
      if (rst) begin
        assert_reset_clear_R7: assert (reg_o[i] == 1'b0);
      end
    end
  end
endmodule

bind mc_block mc_block_chk #(.NUM_CELLS(NUM_CELLS)) i_mc_block_chk (.*);

// File: tb/test_mc_block.sv
module test_mc_block;
  import mc_pkg::*;

  localparam int N     = 32;
  localparam int NCFG  = 1 << CFG_W;
  localparam int ROUNDS = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [NUM_GCLK-1:0] gclk = '0;
  logic                grst = 1'b0;
  logic                gce  = 1'b0;
  logic [N-1:0]        sop  = '0;
  logic [N-1:0]        pad  = '0;
  logic [N-1:0]        ptclk = '0;
  logic [N-1:0]        ptce = '0;
  logic [N*CFG_W-1:0]  cfg  = '0;
  logic [N-1:0]        comb;
  logic [N-1:0]        regq;

  mc_block #(.NUM_CELLS(N)) i_mc_block (
    .gclk_i (gclk), .grst_i (grst), .gce_i (gce),
    .sop_i (sop), .pad_i (pad), .ptclk_i (ptclk), .ptce_i (ptce),
    .cfg_i (cfg), .comb_o (comb), .reg_o (regq)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [N-1:0] m_q    = '0;
  logic [N-1:0] m_pclk = '0;

  // inv, pad_src, sop, pad, expected comb, expected reg after one gclk0 edge
  typedef struct packed {
    logic inv; logic src; logic s; logic p; logic ec; logic er;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  function automatic cell_cfg_t cfg_of(int i);
    return cell_cfg_t'(cfg[i*CFG_W +: CFG_W]);
  endfunction

  function automatic logic sel_clk(int i);
    cell_cfg_t c = cfg_of(i);
    if (c.clk_sel < CSEL_W'(NUM_GCLK)) return gclk[c.clk_sel];
    if (c.clk_sel == CSEL_W'(NUM_GCLK)) return ptclk[i];
    return gclk[0];
  endfunction

  function automatic logic [N-1:0] exp_comb();
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) e[i] = sop[i] ^ cfg_of(i).inv;
    return e;
  endfunction

  task automatic model_step();
    for (int i = 0; i < N; i++) begin
      cell_cfg_t c = cfg_of(i);
      logic ck  = sel_clk(i);
      logic rst = c.rst_hi ? grst : !grst;
      logic en  = !c.ce_use || (c.ce_pt ? ptce[i] : gce);
      logic d   = c.pad_src ? pad[i] : (sop[i] ^ c.inv);
      if (rst) m_q[i] = 1'b0;
      else if (en && (c.latch ? ck : (ck && !m_pclk[i]))) m_q[i] = d;
      m_pclk[i] = ck;
    end
  endtask

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // settle after an input change made just after a negedge of clk
  task automatic settle();
    #1;
    model_step();
  endtask

  task automatic check_both(string rtag);
    check("R1 comb", comb, exp_comb());
    check(rtag, regq, m_q);
  endtask

  task automatic set_all_cfg(cell_cfg_t c);
    for (int i = 0; i < N; i++) cfg[i*CFG_W +: CFG_W] = c;
  endtask

  task automatic pulse_reset(logic hi);
    @(negedge clk); grst = hi;  settle();
    @(negedge clk); grst = !hi; settle();
  endtask

  initial begin
    cell_cfg_t c;

    // reset state: all-zero config has an active-low reset and grst is 0
    @(negedge clk); settle();
    check("R7 reset state", regq, '0);
    check("R1 reset-state comb", comb, '0);
    @(negedge clk); sop = '1; settle();
    @(negedge clk); gclk[0] = 1'b1; settle();
    @(negedge clk); gclk[0] = 1'b0; settle();
    check("R7 edge ignored under reset", regq, '0);

    // vector table: comb and pad/xor source on a plain flop
    foreach (VECS[v]) begin
      @(negedge clk);
      c = '0;
      c.rst_hi  = 1'b1;
      c.inv     = VECS[v].inv;
      c.pad_src = VECS[v].src;
      set_all_cfg(c);
      sop = {N{VECS[v].s}};
      pad = {N{VECS[v].p}};
      settle();
      check("R1 table comb", comb, {N{VECS[v].ec}});
      @(negedge clk); gclk[0] = 1'b1; settle();
      @(negedge clk); gclk[0] = 1'b0; settle();
      check("R2 table reg", regq, {N{VECS[v].er}});
    end

    // every configuration word, 32 cells per batch
    for (int b = 0; b < NCFG / N; b++) begin
      logic hi;
      @(negedge clk);
      for (int i = 0; i < N; i++) cfg[i*CFG_W +: CFG_W] = CFG_W'(b * N + i);
      hi = cfg_of(0).rst_hi;
      grst = !hi;
      settle();
      pulse_reset(hi);
      check("R7 batch reset release", regq, '0);
      for (int r = 0; r < ROUNDS; r++) begin
        @(negedge clk);
        sop = $urandom; pad = $urandom; gce = 1'($urandom); ptce = $urandom;
        settle();
        check_both("R6 R8 data set, clocks low");
        @(negedge clk);
        gclk = NUM_GCLK'($urandom); ptclk = $urandom;
        settle();
        check_both("R3 R5 R8 clock rise");
        @(negedge clk);
        sop = $urandom; pad = $urandom;
        settle();
        check_both("R4 R8 data change, clocks high");
        @(negedge clk);
        gclk = '0; ptclk = '0;
        settle();
        check_both("R4 R3 clock fall");
      end
    end

    // fallback select values follow gclk0 only
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      c = '0;
      c.rst_hi  = 1'b1;
      c.clk_sel = CSEL_W'(5 + i % 3);
      cfg[i*CFG_W +: CFG_W] = c;
    end
    sop = '1; gce = 1'b0;
    settle();
    pulse_reset(1'b1);
    @(negedge clk); gclk = 4'b1110; settle();
    @(negedge clk); gclk = '0;      settle();
    check("R5 select 5..7 ignores gclk1..3", regq, '0);
    @(negedge clk); gclk[0] = 1'b1; settle();
    @(negedge clk); gclk[0] = 1'b0; settle();
    check("R5 select 5..7 follows gclk0", regq, '1);

    // global enable low blocks capture; high allows it
    @(negedge clk);
    c = '0;
    c.rst_hi = 1'b1;
    c.ce_use = 1'b1;
    set_all_cfg(c);
    sop = '0; gce = 1'b0;
    settle();
    @(negedge clk); gclk[0] = 1'b1; settle();
    @(negedge clk); gclk[0] = 1'b0; settle();
    check("R6 enable low holds", regq, '1);
    @(negedge clk); gce = 1'b1; settle();
    @(negedge clk); gclk[0] = 1'b1; settle();
    @(negedge clk); gclk[0] = 1'b0; settle();
    check("R6 enable high captures", regq, '0);

    // reset overrides a transparent latch
    @(negedge clk);
    c = '0;
    c.rst_hi = 1'b1;
    c.latch  = 1'b1;
    set_all_cfg(c);
    settle();
    @(negedge clk); gclk[0] = 1'b1; sop = '1; settle();
    check("R4 latch transparent", regq, '1);
    @(negedge clk); grst = 1'b1; settle();
    check("R7 reset beats transparency", regq, '0);
    @(negedge clk); grst = 1'b0; settle();
    check("R4 latch reopens after reset", regq, '1);
    @(negedge clk); gclk[0] = 1'b0; settle();
    @(negedge clk); sop = '0; settle();
    check("R4 latch holds while clock low", regq, '1);
    check("R1 comb follows sop with latch closed", comb, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule